// File: doc/BRIEF.md
# Two-Level Page-Walk Address Translator

This block turns a 32-bit virtual address into a physical address for a small processor memory system. It checks the privilege mode of the access against a per-mode mapping enable. A disabled mode passes the address through unchanged. An enabled mode starts a two-level page-table walk. The walk reads its tables through a simple request/acknowledge read port and ends with a physical address, a cache-inhibit flag and a fault flag.

Supervisor accesses walk from table base 0 and user accesses from table base 1. A debug caller can supply its own table base, which replaces the mode-selected base and forces a walk even when the mode is unmapped. The block handles one request at a time. It raises `busy` during a walk and pulses `done` when the result is ready. The result stays on the outputs until the next request completes.

Top module: `vaddr_xlate`

## Requirements
- R1: With `priv_user`=0 and `map_sup_en`=0 (and no debug base), the result is `paddr` equal to `req_vaddr`, with `cache_inh`=0 and `fault`=0.
- R2: With `priv_user`=1 and `map_usr_en`=0 (and no debug base), the result is `paddr` equal to `req_vaddr`, with `cache_inh`=0 and `fault`=0.
- R3: A mapped supervisor access walks from `ptbase0` and a mapped user access from `ptbase1`. The first-level read address is {base[31:12], vaddr[31:22], 2'b00}.
- R4: The second-level read address is {entry1[31:12], vaddr[21:12], 2'b00}. On success, `paddr` = {entry2[31:12], vaddr[11:0]}, so the low 12 bits always pass through.
- R5: When `dbg_base_valid`=1, `dbg_base` replaces the mode-selected base. Translation then happens whatever the mode and enables are.
- R6: `cache_inh` is bit 1 of the second-level entry on a successful walk, and 0 for untranslated accesses.
- R7: An entry whose bit 0 (valid) is 0 ends the walk at that level with `fault`=1, `paddr`=0 and `cache_inh`=0. An invalid first-level entry causes no second-level read.
- R8: `busy` is high from acceptance of a mapped request until its result. `done` is a one-cycle pulse with `busy` low. A `req_valid` seen while busy is ignored.
- R9: `paddr`, `cache_inh` and `fault` hold their values until the next `done`.
- R10: Once raised, `mem_rd_req` stays high with a stable `mem_rd_addr` until `mem_rd_ack`. `mem_rd_data` is taken in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a translation (taken when not busy) |
| req_vaddr | input | 32 | Virtual address |
| priv_user | input | 1 | Status mode bit: 1 user, 0 supervisor |
| map_sup_en | input | 1 | Control bit: supervisor accesses are mapped |
| map_usr_en | input | 1 | Control bit: user accesses are mapped |
| ptbase0 | input | 32 | Supervisor table base |
| ptbase1 | input | 32 | User table base |
| dbg_base_valid | input | 1 | Use `dbg_base` and force translation |
| dbg_base | input | 32 | Explicit table base |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| paddr | output | 32 | Physical address |
| cache_inh | output | 1 | Cache-inhibit from the entry |
| fault | output | 1 | Invalid entry met |
| mem_rd_req | output | 1 | Table read request |
| mem_rd_addr | output | 32 | Table read address |
| mem_rd_ack | input | 1 | Read acknowledge, data valid |
| mem_rd_data | input | 32 | Table entry read |

## Verification
`done` is sampled on falling clock edges and counted from the edge that accepts the request. The bench's table memory acknowledges each read on the second falling edge that sees it. With that memory, a pass-through result is due on the first falling edge after acceptance, a first-level fault on the third and a full walk on the sixth. Every request checks this latency exactly, as well as the result values. The outputs are then sampled again several cycles later to confirm they held.

// File: rtl/vaddr_xlate.sv
module vaddr_xlate #(
  parameter int AW = 32,
  parameter int PG_BITS = 12,
  parameter int IDX_BITS = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_vaddr,
  input  logic          priv_user,
  input  logic          map_sup_en,
  input  logic          map_usr_en,
  input  logic [AW-1:0] ptbase0,
  input  logic [AW-1:0] ptbase1,
  input  logic          dbg_base_valid,
  input  logic [AW-1:0] dbg_base,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] paddr,
  output logic          cache_inh,
  output logic          fault,
  output logic          mem_rd_req,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_ack,
  input  logic [AW-1:0] mem_rd_data
);
  localparam int FR_W = AW - PG_BITS;
  localparam int HI_LSB = PG_BITS + IDX_BITS;

  typedef enum logic [1:0] {S_IDLE, S_L1, S_L2} st_t;
  st_t st;

  logic [AW-1:0]   va_q;
  logic [FR_W-1:0] tbl_q;
  logic [AW-1:0]   pa_q;
  logic            ci_q, flt_q, done_q;

  wire mode_mapped = priv_user ? map_usr_en : map_sup_en;
  wire walk = dbg_base_valid | mode_mapped;
  wire [AW-1:0] base_sel = dbg_base_valid ? dbg_base : (priv_user ? ptbase1 : ptbase0);
  wire ent_ok = mem_rd_data[0];

  assign busy = (st != S_IDLE);
  assign mem_rd_req = busy;
  assign mem_rd_addr = (st == S_L1) ? {tbl_q, va_q[AW-1:HI_LSB], 2'b00}
                                    : {tbl_q, va_q[HI_LSB-1:PG_BITS], 2'b00};
  assign done = done_q;
  assign paddr = pa_q;
  assign cache_inh = ci_q;
  assign fault = flt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      va_q <= '0;
      tbl_q <= '0;
      pa_q <= '0;
      ci_q <= 1'b0;
      flt_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        S_IDLE: if (req_valid) begin
          va_q <= req_vaddr;
          if (walk) begin
            tbl_q <= base_sel[AW-1:PG_BITS];
            st <= S_L1;
          end else begin
            pa_q <= req_vaddr;
            ci_q <= 1'b0;
            flt_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
        S_L1: if (mem_rd_ack) begin
          if (ent_ok) begin
            tbl_q <= mem_rd_data[AW-1:PG_BITS];
            st <= S_L2;
          end else begin
            pa_q <= '0;
            ci_q <= 1'b0;
            flt_q <= 1'b1;
            done_q <= 1'b1;
            st <= S_IDLE;
          end
        end
        S_L2: if (mem_rd_ack) begin
          pa_q <= ent_ok ? {mem_rd_data[AW-1:PG_BITS], va_q[PG_BITS-1:0]} : '0;
          ci_q <= ent_ok & mem_rd_data[1];
          flt_q <= ~ent_ok;
          done_q <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && req_valid |=> $stable(va_q));
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_ack |=> mem_rd_req && $stable(mem_rd_addr));
  p_fault_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault |-> paddr == '0 && !cache_inh);
  p_offset_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault |-> paddr[PG_BITS-1:0] == va_q[PG_BITS-1:0]);
  p_hold_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(paddr) && $stable(fault) && $stable(cache_inh));
endmodule

// File: tb/tb_vaddr_xlate.sv
module tb_vaddr_xlate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic priv_user = 1'b0, map_sup_en = 1'b0, map_usr_en = 1'b0;
  logic [31:0] ptbase0 = 32'h0001_0000, ptbase1 = 32'h0002_0000;
  logic dbg_base_valid = 1'b0;
  logic [31:0] dbg_base = 32'h0003_0000;
  logic busy, done, cache_inh, fault, mem_rd_req;
  logic [31:0] paddr, mem_rd_addr;
  logic mem_rd_ack = 1'b0;
  logic [31:0] mem_rd_data = '0;

  always #5 clk = ~clk;

  vaddr_xlate dut (.*);

  typedef struct {logic [31:0] pa; logic ci; logic flt; string tag;} exp_t;
  exp_t q[$];
  exp_t e;
  logic [31:0] mem [logic [31:0]];
  int nchk = 0, nfail = 0;
  int wcnt = 0;
  logic [31:0] first_addr;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rd_ack <= 1'b0;
      wcnt <= 0;
    end else if (mem_rd_ack) begin
      mem_rd_ack <= 1'b0;
      wcnt <= 0;
    end else if (mem_rd_req) begin
      if (wcnt == 0) first_addr <= mem_rd_addr;
      if (wcnt == 1) begin
        chk(mem_rd_addr == first_addr, "R10", "read address moved", mem_rd_addr, first_addr);
        mem_rd_ack <= 1'b1;
        mem_rd_data <= rd(mem_rd_addr);
      end else wcnt <= wcnt + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) chk(0, "R8", "unexpected done", 32'h1, 32'h0);
      else begin
        e = q.pop_front();
        chk(paddr == e.pa, e.tag, "paddr", paddr, e.pa);
        chk(cache_inh == e.ci, e.tag, "cache_inh", {31'b0, cache_inh}, {31'b0, e.ci});
        chk(fault == e.flt, e.tag, "fault", {31'b0, fault}, {31'b0, e.flt});
        chk(!busy, "R8", "busy with done", {31'b0, busy}, 32'h0);
      end
    end
  end

  function automatic exp_t model(input logic [31:0] va, input bit usr, input bit se,
                                 input bit ue, input bit dv, input string tag);
    exp_t r;
    logic [31:0] b, e1, e2;
    r.tag = tag;
    if (!dv && !(usr ? ue : se)) begin
      r.pa = va; r.ci = 0; r.flt = 0; return r;
    end
    b = dv ? dbg_base : (usr ? ptbase1 : ptbase0);
    e1 = rd({b[31:12], va[31:22], 2'b00});
    if (!e1[0]) begin r.pa = 0; r.ci = 0; r.flt = 1; return r; end
    e2 = rd({e1[31:12], va[21:12], 2'b00});
    if (!e2[0]) begin r.pa = 0; r.ci = 0; r.flt = 1; return r; end
    r.pa = {e2[31:12], va[11:0]}; r.ci = e2[1]; r.flt = 0;
    return r;
  endfunction

  task automatic run(input logic [31:0] va, input bit usr, input bit se, input bit ue,
                     input bit dv, input int lat, input string tag, input bit poke);
    exp_t x;
    int cyc;
    x = model(va, usr, se, ue, dv, tag);
    q.push_back(x);
    @(negedge clk);
    req_vaddr = va; priv_user = usr; map_sup_en = se; map_usr_en = ue; dbg_base_valid = dv;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1;
    if (poke) begin
      chk(busy, "R8", "busy during walk", {31'b0, busy}, 32'h1);
      req_vaddr = 32'hDEAD_0000; priv_user = 0; map_sup_en = 0; dbg_base_valid = 0;
      req_valid = 1'b1;
    end
    while (!done && cyc < 50) begin
      @(negedge clk);
      req_valid = 1'b0;
      cyc++;
    end
    chk(cyc == lat, tag, "latency", cyc, lat);
    repeat (3) @(negedge clk);
    chk(paddr == x.pa && fault == x.flt && cache_inh == x.ci, "R9", "held result", paddr, x.pa);
    chk(q.size() == 0, "R8", "pending results", q.size(), 0);
  endtask

  initial begin
    mem[32'h0001_0000] = 32'h0005_0001;
    mem[32'h0005_0120] = 32'h0003_4001;
    mem[32'h0002_0000] = 32'h0006_0001;
    mem[32'h0006_0120] = 32'h0007_7003;
    mem[32'h0003_0000] = 32'h0008_0001;
    mem[32'h0008_0120] = 32'h0009_9001;
    mem[32'h0001_0C04] = 32'h0005_1001;
    mem[32'h0005_1004] = 32'hFEDC_B003;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_rd_req, "R8", "reset idle", {busy, done, mem_rd_req}, 0);
    chk(paddr == 0 && !fault && !cache_inh, "R9", "reset outputs", paddr, 0);
    rst_n = 1'b1;
    run(32'h0004_8123, 0, 0, 1, 0, 1, "R1", 0);
    run(32'hFFFF_F00F, 1, 1, 0, 0, 1, "R2", 0);
    run(32'h0004_8123, 0, 1, 0, 0, 6, "R3", 0);
    run(32'h0004_8123, 1, 0, 1, 0, 6, "R3", 0);
    run(32'hC040_1ABC, 0, 1, 1, 0, 6, "R4", 0);
    run(32'h0004_8123, 0, 0, 0, 1, 6, "R5", 0);
    run(32'h0004_8123, 1, 1, 1, 1, 6, "R5", 0);
    run(32'h0004_8FFF, 1, 0, 1, 0, 6, "R6", 0);
    run(32'h0040_0000, 0, 1, 0, 0, 3, "R7", 0);
    run(32'h0004_9000, 0, 1, 0, 0, 6, "R7", 0);
    run(32'h0004_8123, 0, 0, 1, 0, 1, "R1", 0);
    run(32'h0004_8456, 1, 0, 1, 0, 6, "R8", 1);
    run(32'h0004_8001, 0, 1, 0, 0, 6, "R10", 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL R8 watchdog expired: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end
endmodule